// File: doc/BRIEF.md
# Latched Event Input with Echo-Acknowledge Clear

This block captures short events on sixteen digitized field inputs. Each channel receives two comparator bits. One bit says the field level is at or above the high threshold, nominally 75% of the group supply. The other says the level is below the low threshold, nominally 25%. A hysteresis state machine and a pulse-width counter turn the two bits into a qualified on/off level. A channel's latch sets only when that qualified level goes from off to on. After that the latch ignores its input until the controller acknowledges it.

The controller reads the latches through a parallel-load serial report register, most significant channel first. It then sends the word back inverted through a second serial register. On an explicit apply strobe, a latched channel whose returned bit is 0 is cleared. Every other channel keeps its state. A channel cleared while its input is still on stays clear until the input drops below the low threshold and then qualifies high again.

Top module: `evt_latch_top`

## Requirements
- R1: Each of the 16 channels has its own latch. The latch of channel i sets only at the clock edge where channel i's qualified level changes from off to on. No input of another channel affects it.
- R2: cmp_hi_i[i]=1 means the level is at or above the high threshold, and cmp_lo_i[i]=1 means it is below the low threshold. The qualified level turns off on cmp_lo_i. When both bits are 0, the previous qualified level is kept, so a return to high from that band is not a new event.
- R3: The qualified level turns on only after cmp_hi_i has been sampled 1 on qual_ticks_i consecutive rising edges. The latch sets on the edge that completes the count. A shorter high pulse produces no event.
- R4: While a channel is latched, its transitions are ignored. An event that qualifies during the lockout is not remembered after the latch is cleared.
- R5: After a clear, the channel is re-armed. A new latch needs the input to go off (cmp_lo_i) and then qualify high again, so an input held on across the clear does not relatch.
- R6: A rpt_load_i edge copies all latches into the report register, with bit i holding channel i. rpt_sdo_o then shows bit 15, and each rpt_shift_i edge moves the next lower bit out, filling with 0. Latch changes after the load do not alter the shifted word.
- R7: Each echo_shift_i edge shifts echo_sdi_i into the echo register's LSB, so after 16 shifts the first bit sent applies to channel 15. On echo_apply_i after at least 16 shifts, channel i is cleared when its bit is 0 and it is latched. A bit of 1 leaves the channel unchanged.
- R8: An echo_apply_i after fewer than 16 shifts since the last apply or reset clears no latch and restarts the shift count.
- R9: rst_ni low asynchronously clears all latches, counters and both shift registers, and sets every qualified level to off. Release passes through a two-stage synchronizer, so an input held high through reset qualifies and latches afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_hi_i | input | 16 | Per channel: level at or above high threshold |
| cmp_lo_i | input | 16 | Per channel: level below low threshold |
| qual_ticks_i | input | 16 | Minimum on-width in clock ticks (500 µs worth of clocks in service) |
| rpt_load_i | input | 1 | Snapshot all latches into the report register |
| rpt_shift_i | input | 1 | Shift the report register one bit, MSB first |
| rpt_sdo_o | output | 1 | Report serial data out |
| echo_sdi_i | input | 1 | Inverted echo serial data in |
| echo_shift_i | input | 1 | Shift one echo bit in |
| echo_apply_i | input | 1 | Apply the shifted-in echo to the latches |

## Verification
A latch sets on the rising edge that completes the qual_ticks_i count. The bench holds a high level for exactly that many edges and, as a contrast, for one edge fewer. A load is visible on rpt_sdo_o one edge after rpt_load_i, and each further bit appears one edge after its rpt_shift_i. The bench therefore samples at the falling edge that follows each of these edges. An apply clears at the apply edge itself, and the next report load is issued only after that edge. After reset release, two synchronizer edges pass before any load, so every result is read from registers that have settled.

// File: rtl/elt_pkg.sv
package elt_pkg;
  typedef enum logic {
    LVL_OFF = 1'b0,
    LVL_ON  = 1'b1
  } lvl_e;
endpackage

// File: rtl/elt_rst_sync.sv
module elt_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/elt_channel.sv
module elt_channel
  import elt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_hi_i,
  input  logic             cmp_lo_i,
  input  logic [CNT_W-1:0] qual_ticks_i,
  input  logic             clr_i,
  output logic             latch_o
);
  lvl_e             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             latch_q, latch_d;
  logic             evt;

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);

  // hysteresis and width qualification
  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (lvl_q == LVL_OFF) begin
      if (cmp_hi_i) begin
        if (cnt_inc >= {1'b0, qual_ticks_i}) begin
          lvl_d = LVL_ON;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end else begin
        cnt_d = '0;
      end
    end else begin
      cnt_d = '0;
      if (cmp_lo_i) lvl_d = LVL_OFF;
    end
  end

  assign evt = (lvl_q == LVL_OFF) && (lvl_d == LVL_ON);

  // latch: while set, only an acknowledge may change it
  always_comb begin
    if (latch_q) latch_d = ~clr_i;
    else         latch_d = evt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= LVL_OFF;
      cnt_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      cnt_q   <= cnt_d;
      latch_q <= latch_d;
    end
  end

  assign latch_o = latch_q;

  p_rise_on_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> (lvl_q == LVL_ON && $past(lvl_q) == LVL_OFF));

  p_off_when_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == LVL_ON && cmp_lo_i) |=> (lvl_q == LVL_OFF));

  p_on_needs_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == LVL_ON && $past(lvl_q) == LVL_OFF) |-> $past(cmp_hi_i));

  p_hold_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !clr_i) |=> latch_q);

  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !latch_q);
endmodule

// File: rtl/elt_report_sr.sv
module elt_report_sr #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] par_i,
  input  logic         load_i,
  input  logic         shift_i,
  output logic         sdo_o
);
  logic [N-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_i)       sr_d = par_i;
    else if (shift_i) sr_d = {sr_q[N-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign sdo_o = sr_q[N-1];

  p_load_snapshot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sdo_o == $past(par_i[N-1])));
endmodule

// File: rtl/elt_echo_sr.sv
module elt_echo_sr #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sdi_i,
  input  logic         shift_i,
  input  logic         apply_i,
  input  logic [N-1:0] latched_i,
  output logic [N-1:0] clr_o
);
  localparam int unsigned CW = $clog2(N + 1);
  localparam logic [CW-1:0] FULL = CW'(N);

  logic [N-1:0]  sr_q, sr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full;

  assign full = (cnt_q == FULL);

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (shift_i) begin
      sr_d = {sr_q[N-2:0], sdi_i};
      if (!full) cnt_d = cnt_q + CW'(1);
    end
    if (apply_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  // returned bit 0 acknowledges; only latched channels accept it
  assign clr_o = (apply_i && full) ? (~sr_q & latched_i) : '0;

  p_partial_no_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && cnt_q < FULL) |-> (clr_o == '0));

  p_apply_restarts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |=> (cnt_q == '0));
endmodule

// File: rtl/evt_latch_top.sv
module evt_latch_top #(
  parameter int unsigned NCH   = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   cmp_hi_i,
  input  logic [NCH-1:0]   cmp_lo_i,
  input  logic [CNT_W-1:0] qual_ticks_i,
  input  logic             rpt_load_i,
  input  logic             rpt_shift_i,
  output logic             rpt_sdo_o,
  input  logic             echo_sdi_i,
  input  logic             echo_shift_i,
  input  logic             echo_apply_i
);
  logic           rst_sync_n;
  logic [NCH-1:0] latch_vec;
  logic [NCH-1:0] clr_vec;

  elt_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    elt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_sync_n),
      .cmp_hi_i     (cmp_hi_i[g]),
      .cmp_lo_i     (cmp_lo_i[g]),
      .qual_ticks_i (qual_ticks_i),
      .clr_i        (clr_vec[g]),
      .latch_o      (latch_vec[g])
    );
  end

  elt_report_sr #(.N(NCH)) u_rpt (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .par_i   (latch_vec),
    .load_i  (rpt_load_i),
    .shift_i (rpt_shift_i),
    .sdo_o   (rpt_sdo_o)
  );

  elt_echo_sr #(.N(NCH)) u_echo (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .sdi_i     (echo_sdi_i),
    .shift_i   (echo_shift_i),
    .apply_i   (echo_apply_i),
    .latched_i (latch_vec),
    .clr_o     (clr_vec)
  );

  p_clear_only_latched_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (clr_vec & ~latch_vec) == '0);
endmodule

// File: tb/evt_latch_top_bench.sv
module evt_latch_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cmp_hi, cmp_lo;
  logic [15:0] qual_ticks;
  logic        rpt_load, rpt_shift, rpt_sdo;
  logic        echo_sdi, echo_shift, echo_apply;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] got;
  event        rpt_done;

  always #5 clk = ~clk;

  evt_latch_top u_evt_latch_top (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmp_hi_i     (cmp_hi),
    .cmp_lo_i     (cmp_lo),
    .qual_ticks_i (qual_ticks),
    .rpt_load_i   (rpt_load),
    .rpt_shift_i  (rpt_shift),
    .rpt_sdo_o    (rpt_sdo),
    .echo_sdi_i   (echo_sdi),
    .echo_shift_i (echo_shift),
    .echo_apply_i (echo_apply)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the expected word for every report shifted out
  initial begin
    forever begin
      @(rpt_done);
      chk(got === exp_q[0], tag_q[0], got, exp_q[0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic read_rpt(input logic [15:0] poke);
    @(negedge clk) rpt_load = 1'b1;
    @(negedge clk) rpt_load = 1'b0;
    cmp_hi = cmp_hi | poke;
    cmp_lo = cmp_lo & ~poke;
    for (int i = 15; i >= 0; i--) begin
      got[i]    = rpt_sdo;
      rpt_shift = 1'b1;
      @(negedge clk);
      rpt_shift = 1'b0;
    end
    -> rpt_done;
  endtask

  task automatic expect_rpt(input logic [15:0] v, input string tag, input logic [15:0] poke);
    exp_q.push_back(v);
    tag_q.push_back(tag);
    read_rpt(poke);
  endtask

  task automatic send_echo(input logic [15:0] w, input int nbits);
    for (int i = 15; i >= 16 - nbits; i--) begin
      @(negedge clk);
      echo_sdi   = w[i];
      echo_shift = 1'b1;
    end
    @(negedge clk) echo_shift = 1'b0;
    echo_apply = 1'b1;
    @(negedge clk) echo_apply = 1'b0;
  endtask

  task automatic pulse(input int ch, input int len);
    @(negedge clk);
    cmp_hi[ch] = 1'b1;
    cmp_lo[ch] = 1'b0;
    repeat (len) @(negedge clk);
    cmp_hi[ch] = 1'b0;
    cmp_lo[ch] = 1'b1;
    @(negedge clk);
  endtask

  task automatic hold_high(input int ch, input int len);
    @(negedge clk);
    cmp_hi[ch] = 1'b1;
    cmp_lo[ch] = 1'b0;
    repeat (len) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmp_hi = '0; cmp_lo = '1; qual_ticks = 16'd4;
    rpt_load = 1'b0; rpt_shift = 1'b0;
    echo_sdi = 1'b0; echo_shift = 1'b0; echo_apply = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    expect_rpt(16'h0000, "R9 reset state", '0);

    // R3 full width latches, one tick short does not; R1 per channel
    pulse(3, 4);
    pulse(5, 3);
    expect_rpt(16'h0008, "R3 width / R1 channel", '0);

    // R7 selective acknowledge
    pulse(9, 4);
    send_echo(~16'h0008, 16);
    expect_rpt(16'h0200, "R7 selective clear", '0);

    // R8 partial echo clears nothing
    send_echo(16'h0000, 8);
    expect_rpt(16'h0200, "R8 partial echo", '0);
    send_echo(16'h0000, 16);
    expect_rpt(16'h0000, "R7 full echo clear", '0);

    // R2 hysteresis band, R5 re-arm
    hold_high(7, 6);
    cmp_hi[7] = 1'b0;
    expect_rpt(16'h0080, "R2 latch on high", '0);
    send_echo(~16'h0080, 16);
    hold_high(7, 6);
    cmp_hi[7] = 1'b0;
    expect_rpt(16'h0000, "R2 band holds on", '0);
    cmp_lo[7] = 1'b1;
    repeat (2) @(negedge clk);
    pulse(7, 4);
    expect_rpt(16'h0080, "R5 relatch after off", '0);
    send_echo(~16'h0080, 16);

    // R4 lockout: event while latched is dropped; held high does not relatch (R5)
    pulse(12, 4);
    hold_high(12, 6);
    send_echo(~16'h1000, 16);
    expect_rpt(16'h0000, "R4 lockout / R5 held high", '0);
    cmp_hi[12] = 1'b0; cmp_lo[12] = 1'b1;

    // R6 snapshot isolated from later latch changes; fill with zero
    expect_rpt(16'h0000, "R6 snapshot", 16'h0001);
    @(negedge clk);
    chk(rpt_sdo === 1'b0, "R6 zero fill", {15'h0, rpt_sdo}, 16'h0000);
    expect_rpt(16'h0001, "R6 next snapshot", '0);
    cmp_hi[0] = 1'b0; cmp_lo[0] = 1'b1;

    // R9 reset clears latches and drops the qualified level
    pulse(2, 4);
    @(negedge clk);
    cmp_hi[2] = 1'b1; cmp_lo[2] = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_rpt(16'h0000, "R9 cleared by reset", '0);
    expect_rpt(16'h0004, "R9 requalify after reset", '0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule